// File: doc/BRIEF.md
# Configurable GPIO Port Bank

A bank of four byte-wide general-purpose ports behind a simple register bus. Each port holds an output latch that software writes, and a read of the same address returns the levels seen on the pins after a two-stage synchronizer. A 2-bit mode per port selects how the latch reaches the pad. The modes are pull-up input, open-drain output and push-pull output. The block drives per-pin output-enable, output-value and pull-up-enable signals to an external pad model.

The highest port has only seven bonded pins. The missing eighth bit never drives or pulls its pad. It reads back its own latch value, so software always sees a defined level. Every bonded pin also has an interrupt latch. The latch sets when the synchronized input changes in either direction, and software clears it by writing 1 to the matching status bit. A single interrupt line is the OR of all status bits.

Top module: `gpio_bank`

## Requirements
- R1: After reset all output latches are 1, all port modes are 00, all interrupt status bits are 0, irq is 0, pad_oe is 0 and pad_pu is 1 on every bonded pin. Pin bit 8*p+b is bit b of port p, and bit 31 is not bonded.
- R2: A bus write to address p (0..3) loads the port p output latch with bus_wdata on the next clock edge. pad_out carries the latch value on every bonded pin in every mode.
- R3: Modes 00 (pull-up input) and 11 (reserved) both give pad_oe=0 and pad_pu=1 on the port's bonded pins.
- R4: Mode 01 (open-drain): a pin whose latch is 0 has pad_oe=1, pad_out=0 and pad_pu=0. A pin whose latch is 1 has pad_oe=0 and pad_pu=1.
- R5: Mode 10 (push-pull): every bonded pin of the port has pad_oe=1 and pad_pu=0, and pad_out follows the latch.
- R6: The mode register sits at address 0x04, with port p in bits [2p+1:2p]. It is written by a bus write and reads back the same value.
- R7: A read of address p returns the synchronized pin levels of port p. A pin change made before clock edge k is first visible on bus_rdata after edge k+1.
- R8: Bit 7 of port 3 reads as its latch value. Its pad_oe, pad_out and pad_pu are always 0, and a change on pin_in[31] never sets an interrupt.
- R9: A change of a synchronized input bit sets its interrupt status bit on the edge after the change reaches bus_rdata (edge k+2 for a pin change before edge k). The status of port p reads at address 0x08+p, and irq is 1 when any status bit is 1.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a new change and a clear hit the same edge, the bit stays set.
- R11: Addresses 0x05-0x07 and 0x0C-0x0F read as 0, and writes to them change no latch, mode or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 32 | Pin levels from the pads, asynchronous |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output value |
| pad_pu | output | 32 | Per-pin pull-up enable |
| irq | output | 1 | OR of all interrupt status bits |

## Verification
One configuration puts a different mode on each of the four ports, including the reserved code. A single write pattern on the pads then separates the open-drain, push-pull and input decodes bit by bit, and the latch values are chosen so that no two modes give the same pad triple. Pin changes are observed cycle by cycle: the read one edge after a change must still show the old level, and the status read one edge later must still be clear. This separates a correct synchronizer depth from one stage too few or too many. Status clearing is tried with zero, partial and full write masks, and with a clear that lands on the same edge as a new change. Writes to unused addresses and a toggle on the unbonded pin are checked for having no effect, both through the pads and through read-back.

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank #(
  parameter int NPORT    = 4,
  parameter int PW       = 8,
  parameter int LAST_W   = 7,
  parameter int AW       = 4,
  parameter int MODE_ADR = 4,
  parameter int STAT_ADR = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       bus_addr,
  input  logic                bus_wr,
  input  logic [PW-1:0]       bus_wdata,
  output logic [PW-1:0]       bus_rdata,
  input  logic [NPORT*PW-1:0] pin_in,
  output logic [NPORT*PW-1:0] pad_oe,
  output logic [NPORT*PW-1:0] pad_out,
  output logic [NPORT*PW-1:0] pad_pu,
  output logic                irq
);
  localparam int TOT = NPORT * PW;
  localparam int MW  = 2 * NPORT;
  localparam logic [TOT-1:0] BOND = {{(PW-LAST_W){1'b0}}, {(TOT-PW+LAST_W){1'b1}}};

  logic [TOT-1:0] out_q, s1_q, s2_q, s3_q, int_q, chg, od_bits;
  logic [MW-1:0]  mode_q;
  logic [PW-1:0]  rd_port [NPORT];
  logic [PW-1:0]  rd_stat [NPORT];

  assign chg = (s2_q ^ s3_q) & BOND;
  assign irq = |int_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
      s3_q <= '1;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (bus_wr && bus_addr == AW'(MODE_ADR))
      mode_q <= bus_wdata[MW-1:0];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [AW-1:0] DADR = AW'(p);
    localparam logic [AW-1:0] SADR = AW'(STAT_ADR + p);
    logic [1:0]    m;
    logic          is_pp, is_od;
    logic [PW-1:0] lat, bnd, clr;

    assign m     = mode_q[2*p +: 2];
    assign is_pp = (m == 2'b10);
    assign is_od = (m == 2'b01);
    assign lat   = out_q[p*PW +: PW];
    assign bnd   = BOND[p*PW +: PW];
    assign clr   = (bus_wr && bus_addr == SADR) ? bus_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        out_q[p*PW +: PW] <= '1;
      else if (bus_wr && bus_addr == DADR)
        out_q[p*PW +: PW] <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        int_q[p*PW +: PW] <= '0;
      else
        int_q[p*PW +: PW] <= (int_q[p*PW +: PW] & ~clr) | chg[p*PW +: PW];
    end

    assign pad_out[p*PW +: PW] = lat & bnd;
    assign pad_oe[p*PW +: PW]  = (is_pp ? '1 : is_od ? ~lat : '0) & bnd;
    assign pad_pu[p*PW +: PW]  = (is_pp ? '0 : is_od ? lat : '1) & bnd;
    assign od_bits[p*PW +: PW] = is_od ? bnd : '0;
    assign rd_port[p] = (s2_q[p*PW +: PW] & bnd) | (lat & ~bnd);
    assign rd_stat[p] = int_q[p*PW +: PW];

    p_latch_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == DADR) |=> (out_q[p*PW +: PW] == $past(bus_wdata)));
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr == AW'(p))            bus_rdata = rd_port[p];
      if (bus_addr == AW'(STAT_ADR + p)) bus_rdata = rd_stat[p];
    end
    if (bus_addr == AW'(MODE_ADR)) bus_rdata = PW'(mode_q);
  end

  p_od_never_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & od_bits) == '0);

  p_int_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_q & $past(chg)) == $past(chg)));

  p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(MODE_ADR)) |=> (mode_q == $past(bus_wdata[MW-1:0])));

  p_unbonded_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_q & ~BOND) == '0);
endmodule

// File: tb/gpio_bank_tb.sv
`timescale 1ns/1ps
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [31:0] pin_in = '1;
  logic [31:0] pad_oe, pad_out, pad_pu;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .irq(irq)
  );

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(logic [31:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic exp_rd(logic [3:0] a, logic [7:0] e, string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = {24'h0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_sig(int kind, logic [31:0] e, string tag);
    item_t it;
    @(negedge clk);
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0: act = {24'h0, bus_rdata};
          1: act = pad_oe;
          2: act = pad_out;
          3: act = pad_pu;
          default: act = {31'h0, irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    exp_sig(1, 32'h0000_0000, "R1 pad_oe");
    exp_sig(3, 32'h7FFF_FFFF, "R1 pad_pu");
    exp_sig(2, 32'h7FFF_FFFF, "R1/R8 pad_out");
    exp_sig(4, 32'h0, "R1 irq");
    exp_rd(4'h4, 8'h00, "R1 mode");
    exp_rd(4'hB, 8'h00, "R1 status3");

    // R6 modes: p0=00 p1=01 p2=10 p3=11
    wr(4'h4, 8'hE4);
    exp_rd(4'h4, 8'hE4, "R6 mode readback");

    // R2 latches
    wr(4'h0, 8'hA5);
    wr(4'h1, 8'h3C);
    wr(4'h2, 8'h5A);
    wr(4'h3, 8'hF0);
    exp_sig(2, 32'h705A_3CA5, "R2/R8 pad_out");
    exp_sig(1, 32'h00FF_C300, "R3/R4/R5 pad_oe");
    exp_sig(3, 32'h7F00_3CFF, "R3/R4/R5 pad_pu");

    // R7 / R8 readback
    exp_rd(4'h0, 8'hFF, "R7 pins high");
    exp_rd(4'h3, 8'hFF, "R8 bit7 latch 1");
    wr(4'h3, 8'h70);
    exp_rd(4'h3, 8'h7F, "R8 bit7 latch 0");

    // R7 latency, R9 timing
    set_pins(32'hFFFF_FF0F);
    exp_rd(4'h0, 8'hFF, "R7 one edge old");
    exp_rd(4'h8, 8'h00, "R9 not yet set");
    exp_rd(4'h8, 8'hF0, "R9 status set");
    exp_rd(4'h0, 8'h0F, "R7 new level");
    exp_sig(4, 32'h1, "R9 irq");

    // R8 unbonded pin toggle
    set_pins(32'h7FFF_FF0F);
    idle(3);
    exp_rd(4'hB, 8'h00, "R8 no int on bit31");
    exp_rd(4'h3, 8'h7F, "R8 read ignores pin");

    // R10 clearing
    wr(4'h8, 8'h00);
    exp_rd(4'h8, 8'hF0, "R10 write0 keeps");
    wr(4'h8, 8'h30);
    exp_rd(4'h8, 8'hC0, "R10 partial clear");
    wr(4'h8, 8'hC0);
    exp_rd(4'h8, 8'h00, "R10 full clear");
    exp_sig(4, 32'h0, "R10 irq low");

    // R9 rising change
    set_pins(32'h7FFF_FFFF);
    idle(2);
    exp_rd(4'h8, 8'hF0, "R9 rising change");
    wr(4'h8, 8'hFF);

    // R10 set wins over clear on the same edge
    set_pins(32'h7FFE_FFFF);
    idle(1);
    wr(4'hA, 8'h01);
    exp_rd(4'hA, 8'h01, "R10 set priority");
    wr(4'hA, 8'h01);
    exp_rd(4'hA, 8'h00, "R10 cleared after");

    // R11 unused addresses
    wr(4'h5, 8'h00);
    wr(4'hF, 8'h00);
    wr(4'h6, 8'hFF);
    exp_rd(4'h5, 8'h00, "R11 read 0x05");
    exp_rd(4'hC, 8'h00, "R11 read 0x0C");
    exp_sig(2, 32'h705A_3CA5, "R11 latches kept");
    exp_rd(4'h4, 8'hE4, "R11 mode kept");

    // R4 open-drain release, R5 push-pull follow
    wr(4'h1, 8'hFF);
    wr(4'h2, 8'h00);
    exp_sig(1, 32'h00FF_0000, "R4 release / R5 oe");
    exp_sig(3, 32'h7F00_FFFF, "R4 pull-up on release");
    exp_sig(2, 32'h7000_FFA5, "R5 follows latch");

    // R3 -> R5 mode change on port 0
    wr(4'h4, 8'hE6);
    exp_sig(1, 32'h00FF_00FF, "R5 port0 push-pull");
    exp_sig(3, 32'h7F00_FF00, "R5 port0 no pull-up");

    idle(3);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule